// File: doc/BRIEF.md
# Remote Memory Reply Packet Builder

This block sits on the transmit side of a remote memory access target. A decoder and memory stage upstream hand it a decoded command record: return path bytes, the source and destination logical addresses, the instruction byte, the transaction identifier, a status byte and, for reads, a byte count. The block turns that record into a reply packet. It sends the packet one byte at a time on a valid/ready transmit port and closes it with a separate end-of-packet beat.

The reply is routed back by the command's return path. Leading zero bytes of that path are dropped. The instruction byte is sent back in reply form, and the transaction identifier is echoed so the requester can pair posted operations with their replies. A header CRC is computed while the bytes go out. A read reply also pulls its data from a byte stream and appends a second CRC that covers the data only. A write reply is produced only when the command asked for an acknowledge. No reply is produced when the command header was damaged. The upstream stage raises `start_i` only after the memory write of a command has completed, so a write reply always follows its write.

Top module: `rrb_reply_builder`

## Requirements
- R1: An acknowledged write reply carries, in this order: the kept return path bytes, the source logical address, the protocol byte, the reply instruction byte, the status, the destination logical address, the transaction ID high byte, the transaction ID low byte, the header CRC, and then the end-of-packet beat.
- R2: A write command (instruction bit 5 = 1) with its acknowledge bit (bit 3) clear produces no transmit beat, and `busy_o` is low in the cycle after `start_i`.
- R3: When `header_ok_i` is low at start, no beat is sent for either a read or a write, and `busy_o` stays low.
- R4: The protocol byte is 0x01. The reply instruction byte equals the command's instruction byte with bit 6 (packet type) forced to 0.
- R5: The transaction ID is echoed unchanged, high byte first.
- R6: A read reply (instruction bit 5 = 0) carries, in this order: the path bytes, the source logical address, the protocol byte, the instruction byte, the status, the destination logical address, the transaction ID (two bytes), a 0x00 byte, the 24-bit length (high byte first), the header CRC, the data bytes taken in stream order, the data CRC, and then the end-of-packet beat.
- R7: Of the first `path_len_i` bytes of `path_i` (byte k at bits 8k+7:8k, byte 0 first), the leading zero bytes are skipped. Every byte from the first nonzero one onward is sent, including later zero bytes.
- R8: The header CRC is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, and the most significant bit of each byte first. It covers the bytes from the source logical address through the byte just before the CRC, and never the path bytes.
- R9: The data CRC uses the same CRC-8 starting again from 0x00 and covers only the data bytes.
- R10: A read with a nonzero status sends a length field of 0, takes no byte from the data stream, and still sends the data CRC byte (0x00). A read with status 0 and length 0 behaves the same way.
- R11: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o`, `tx_data_o` and `tx_eop_o` hold their values into the next cycle.
- R12: End of packet is a beat of its own with `tx_eop_o` = 1 and data 0x00, after which `busy_o` is low. After reset, `busy_o`, `tx_valid_o` and `dat_ready_o` are low.
- R13: `start_i` is ignored while `busy_o` is high. The current reply finishes unchanged and no extra packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Record valid; taken when not busy |
| busy_o | output | 1 | A reply is in progress |
| header_ok_i | input | 1 | Command header arrived intact |
| path_i | input | 8*PATH_MAX | Return path bytes, byte 0 in the low bits |
| path_len_i | input | $clog2(PATH_MAX+1) | Number of return path bytes present |
| src_la_i | input | 8 | Requester logical address |
| dst_la_i | input | 8 | Target logical address |
| instr_i | input | 8 | Command instruction byte |
| tid_i | input | 16 | Transaction identifier |
| status_i | input | 8 | Reply status, 0 = success |
| data_len_i | input | 24 | Read byte count |
| dat_valid_i | input | 1 | Read data byte available |
| dat_i | input | 8 | Read data byte |
| dat_ready_o | output | 1 | Read data byte taken |
| tx_valid_o | output | 1 | Transmit beat valid |
| tx_ready_i | input | 1 | Link accepts the beat |
| tx_data_o | output | 8 | Transmit byte |
| tx_eop_o | output | 1 | Beat is the end-of-packet marker |

## Verification
A wrong path index or header index shows up at the port in the very next accepted beat, as a byte that is missing, repeated or out of place. A CRC register that was cleared or updated at the wrong moment shows up only at the CRC byte, which comes several beats later. A stale data counter shows up as a data byte too many or too few, or as a fetch from the data stream on an error reply. For that reason the bench compares whole packets byte by byte against packets it builds itself, under steady and random backpressure, and it counts the fetches from the data stream.

// File: rtl/rrb_pkg.sv
`timescale 1ns/1ps
package rrb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_PATH, ST_HDR, ST_DATA, ST_DCRC, ST_EOP
  } st_e;

  localparam int unsigned TYPE_BIT  = 6;
  localparam int unsigned WRITE_BIT = 5;
  localparam int unsigned ACK_BIT   = 3;
  localparam int unsigned LEN_W     = 24;
  localparam int unsigned HIDX_W    = 4;

  function automatic logic [7:0] crc8_step(input logic [7:0] crc,
                                           input logic [7:0] b,
                                           input logic [7:0] poly);
    logic [7:0] c;
    c = crc ^ b;
    for (int i = 0; i < 8; i++) c = c[7] ? ((c << 1) ^ poly) : (c << 1);
    return c;
  endfunction
endpackage

// File: rtl/rrb_crc8.sv
`timescale 1ns/1ps
module rrb_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       en_i,
  input  logic [7:0] byte_i,
  output logic [7:0] crc_o
);
  logic [7:0] crc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    crc_q <= '0;
    else if (clr_i) crc_q <= '0;
    else if (en_i)  crc_q <= rrb_pkg::crc8_step(crc_q, byte_i, POLY);
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/rrb_path_scan.sv
`timescale 1ns/1ps
module rrb_path_scan #(
  parameter int unsigned PATH_MAX = 12,
  localparam int unsigned IDX_W = $clog2(PATH_MAX + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [8*PATH_MAX-1:0] path_i,
  input  logic [IDX_W-1:0]      len_i,
  output logic [IDX_W-1:0]      first_o,
  output logic                  found_o
);
  logic [PATH_MAX-1:0] nz;

  for (genvar k = 0; k < PATH_MAX; k++) begin : g_nz
    assign nz[k] = (path_i[8*k +: 8] != 8'h00) && (len_i > IDX_W'(k));
  end

  always_comb begin
    found_o = 1'b0;
    first_o = '0;
    for (int k = PATH_MAX - 1; k >= 0; k--) begin
      if (nz[k]) begin
        found_o = 1'b1;
        first_o = IDX_W'(k);
      end
    end
  end

  p_first_nz_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (path_i[{first_o, 3'b000} +: 8] != 8'h00) && (first_o < len_i));
endmodule

// File: rtl/rrb_hdr_mux.sv
`timescale 1ns/1ps
module rrb_hdr_mux #(
  parameter logic [7:0] PROTO_ID = 8'h01
) (
  input  logic [rrb_pkg::HIDX_W-1:0] idx_i,
  input  logic                       is_read_i,
  input  logic [7:0]                 src_la_i,
  input  logic [7:0]                 dst_la_i,
  input  logic [7:0]                 instr_i,
  input  logic [7:0]                 status_i,
  input  logic [15:0]                tid_i,
  input  logic [rrb_pkg::LEN_W-1:0]  len_i,
  input  logic [7:0]                 crc_i,
  output logic [7:0]                 byte_o,
  output logic                       last_o
);
  localparam logic [rrb_pkg::HIDX_W-1:0] WR_LAST = 4'd7;
  localparam logic [rrb_pkg::HIDX_W-1:0] RD_LAST = 4'd11;

  logic [7:0] instr_rep;

  always_comb begin
    instr_rep = instr_i;
    instr_rep[rrb_pkg::TYPE_BIT] = 1'b0;
  end

  assign last_o = (idx_i == (is_read_i ? RD_LAST : WR_LAST));

  always_comb begin
    unique case (idx_i)
      4'd0:    byte_o = src_la_i;
      4'd1:    byte_o = PROTO_ID;
      4'd2:    byte_o = instr_rep;
      4'd3:    byte_o = status_i;
      4'd4:    byte_o = dst_la_i;
      4'd5:    byte_o = tid_i[15:8];
      4'd6:    byte_o = tid_i[7:0];
      4'd7:    byte_o = is_read_i ? 8'h00 : crc_i;
      4'd8:    byte_o = len_i[23:16];
      4'd9:    byte_o = len_i[15:8];
      4'd10:   byte_o = len_i[7:0];
      default: byte_o = crc_i;
    endcase
  end
endmodule

// File: rtl/rrb_reply_builder.sv
`timescale 1ns/1ps
module rrb_reply_builder #(
  parameter int unsigned PATH_MAX = 12,
  parameter logic [7:0]  PROTO_ID = 8'h01,
  parameter logic [7:0]  CRC_POLY = 8'h07,
  localparam int unsigned IDX_W = $clog2(PATH_MAX + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  input  logic                      header_ok_i,
  input  logic [8*PATH_MAX-1:0]     path_i,
  input  logic [IDX_W-1:0]          path_len_i,
  input  logic [7:0]                src_la_i,
  input  logic [7:0]                dst_la_i,
  input  logic [7:0]                instr_i,
  input  logic [15:0]               tid_i,
  input  logic [7:0]                status_i,
  input  logic [rrb_pkg::LEN_W-1:0] data_len_i,
  input  logic                      dat_valid_i,
  input  logic [7:0]                dat_i,
  output logic                      dat_ready_o,
  output logic                      tx_valid_o,
  input  logic                      tx_ready_i,
  output logic [7:0]                tx_data_o,
  output logic                      tx_eop_o
);
  import rrb_pkg::*;

  st_e                   state_q;
  logic [8*PATH_MAX-1:0] path_q;
  logic [IDX_W-1:0]      plen_q, pidx_q;
  logic [HIDX_W-1:0]     hidx_q;
  logic [7:0]            src_la_q, dst_la_q, instr_q, status_q, dbyte_q;
  logic [15:0]           tid_q;
  logic [LEN_W-1:0]      len_q, rem_q;
  logic                  is_read_q, have_q;

  logic [IDX_W-1:0] scan_first;
  logic             scan_found;
  logic [7:0]       hdr_byte, hcrc, dcrc;
  logic             hdr_last, tx_fire, dat_fire;
  logic             in_is_read, in_send;

  rrb_path_scan #(.PATH_MAX(PATH_MAX)) u_scan (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .path_i(path_i), .len_i(path_len_i),
    .first_o(scan_first), .found_o(scan_found)
  );

  rrb_hdr_mux #(.PROTO_ID(PROTO_ID)) u_hdr (
    .idx_i(hidx_q), .is_read_i(is_read_q),
    .src_la_i(src_la_q), .dst_la_i(dst_la_q), .instr_i(instr_q),
    .status_i(status_q), .tid_i(tid_q), .len_i(len_q), .crc_i(hcrc),
    .byte_o(hdr_byte), .last_o(hdr_last)
  );

  rrb_crc8 #(.POLY(CRC_POLY)) u_hcrc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q == ST_IDLE),
    .en_i((state_q == ST_HDR) && tx_fire && !hdr_last),
    .byte_i(hdr_byte), .crc_o(hcrc)
  );

  rrb_crc8 #(.POLY(CRC_POLY)) u_dcrc (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(state_q == ST_IDLE),
    .en_i((state_q == ST_DATA) && tx_fire),
    .byte_i(dbyte_q), .crc_o(dcrc)
  );

  assign in_is_read = !instr_i[WRITE_BIT];
  assign in_send    = header_ok_i && (in_is_read || instr_i[ACK_BIT]);

  // Output beat selection: every source is a register, so a stalled beat holds
  always_comb begin
    tx_valid_o = 1'b0;
    tx_data_o  = 8'h00;
    tx_eop_o   = 1'b0;
    unique case (state_q)
      ST_PATH: begin tx_valid_o = 1'b1; tx_data_o = path_q[{pidx_q, 3'b000} +: 8]; end
      ST_HDR:  begin tx_valid_o = 1'b1; tx_data_o = hdr_byte; end
      ST_DATA: begin tx_valid_o = have_q; tx_data_o = dbyte_q; end
      ST_DCRC: begin tx_valid_o = 1'b1; tx_data_o = dcrc; end
      ST_EOP:  begin tx_valid_o = 1'b1; tx_eop_o = 1'b1; end
      default: ;
    endcase
  end

  assign tx_fire     = tx_valid_o && tx_ready_i;
  assign dat_ready_o = (state_q == ST_DATA) && !have_q;
  assign dat_fire    = dat_valid_i && dat_ready_o;
  assign busy_o      = (state_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      path_q    <= '0;
      plen_q    <= '0;
      pidx_q    <= '0;
      hidx_q    <= '0;
      src_la_q  <= '0;
      dst_la_q  <= '0;
      instr_q   <= '0;
      status_q  <= '0;
      tid_q     <= '0;
      len_q     <= '0;
      rem_q     <= '0;
      is_read_q <= 1'b0;
      have_q    <= 1'b0;
      dbyte_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          path_q    <= path_i;
          plen_q    <= path_len_i;
          pidx_q    <= scan_first;
          hidx_q    <= '0;
          src_la_q  <= src_la_i;
          dst_la_q  <= dst_la_i;
          instr_q   <= instr_i;
          status_q  <= status_i;
          tid_q     <= tid_i;
          is_read_q <= in_is_read;
          have_q    <= 1'b0;
          len_q     <= (in_is_read && status_i == 8'h00) ? data_len_i : '0;
          if (in_send) state_q <= scan_found ? ST_PATH : ST_HDR;
        end
        ST_PATH: if (tx_fire) begin
          if ((pidx_q + IDX_W'(1)) == plen_q) state_q <= ST_HDR;
          else pidx_q <= pidx_q + IDX_W'(1);
        end
        ST_HDR: if (tx_fire) begin
          if (!hdr_last) hidx_q <= hidx_q + HIDX_W'(1);
          else if (!is_read_q) state_q <= ST_EOP;
          else if (len_q != '0) begin
            state_q <= ST_DATA;
            rem_q   <= len_q;
          end else state_q <= ST_DCRC;
        end
        ST_DATA: begin
          if (dat_fire) begin
            have_q  <= 1'b1;
            dbyte_q <= dat_i;
          end
          if (tx_fire) begin
            have_q <= 1'b0;
            rem_q  <= rem_q - LEN_W'(1);
            if (rem_q == LEN_W'(1)) state_q <= ST_DCRC;
          end
        end
        ST_DCRC: if (tx_fire) state_q <= ST_EOP;
        ST_EOP:  if (tx_fire) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_hold_stable_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o) && $stable(tx_eop_o));

  p_eop_ends_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_eop_o |=> !busy_o);

  p_noack_silent_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && instr_i[WRITE_BIT] && !instr_i[ACK_BIT] |=> !busy_o);

  p_bad_hdr_silent_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && start_i && !header_ok_i |=> !busy_o);

  p_err_no_data_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA) |-> (status_q == 8'h00) && (rem_q != '0));

  p_busy_start_ignored_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && !tx_eop_o |=> busy_o && $stable(tid_q));
endmodule

// File: tb/tb_rrb_reply_builder.sv
`timescale 1ns/1ps
module tb_rrb_reply_builder;
  localparam int PATH_MAX = 12;
  localparam int IDX_W = $clog2(PATH_MAX + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                  start_i = 0, header_ok_i = 1;
  logic [8*PATH_MAX-1:0] path_i = '0;
  logic [IDX_W-1:0]      path_len_i = '0;
  logic [7:0]            src_la_i = 0, dst_la_i = 0, instr_i = 0, status_i = 0, dat_i = 0;
  logic [15:0]           tid_i = 0;
  logic [23:0]           data_len_i = 0;
  logic                  dat_valid_i = 1, tx_ready_i = 1;
  logic                  busy_o, dat_ready_o, tx_valid_o, tx_eop_o;
  logic [7:0]            tx_data_o;

  rrb_reply_builder #(.PATH_MAX(PATH_MAX)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i), .busy_o(busy_o),
    .header_ok_i(header_ok_i), .path_i(path_i), .path_len_i(path_len_i),
    .src_la_i(src_la_i), .dst_la_i(dst_la_i), .instr_i(instr_i), .tid_i(tid_i),
    .status_i(status_i), .data_len_i(data_len_i), .dat_valid_i(dat_valid_i),
    .dat_i(dat_i), .dat_ready_o(dat_ready_o), .tx_valid_o(tx_valid_o),
    .tx_ready_i(tx_ready_i), .tx_data_o(tx_data_o), .tx_eop_o(tx_eop_o)
  );

  int checks = 0, fails = 0, fetched = 0, src_idx = 0;
  bit rdy_rand = 0;
  logic [15:0] lfsr = 16'hACE1;
  int got[$];
  int exp[$];

  function automatic logic [7:0] mem_byte(int i);
    return 8'(i * 37 + 11);
  endfunction

  function automatic logic [7:0] crc_upd(logic [7:0] c, logic [7:0] b);
    logic fb;
    for (int k = 7; k >= 0; k--) begin
      fb = c[7] ^ b[k];
      c = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
    end
  endtask

  // link ready pattern, changed just after the rising edge
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    tx_ready_i = rdy_rand ? lfsr[0] : 1'b1;
  end

  // read data stream, advanced after each accepted fetch
  initial forever begin
    bit f;
    @(negedge clk);
    f = dat_valid_i && dat_ready_o;
    @(posedge clk); #1;
    if (f) begin
      src_idx++;
      fetched++;
      dat_i = mem_byte(src_idx);
    end
  end

  // beat monitor and stall-hold check (R11)
  logic       prev_stall = 0;
  logic [8:0] prev_beat = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(tx_valid_o && {tx_eop_o, tx_data_o} == prev_beat, "R11 held beat",
              {tx_valid_o, tx_eop_o, tx_data_o}, {1'b1, prev_beat});
      if (tx_valid_o && tx_ready_i) got.push_back(int'({tx_eop_o, tx_data_o}));
      prev_stall = tx_valid_o && !tx_ready_i;
      prev_beat  = {tx_eop_o, tx_data_o};
    end
  end

  function automatic void build_exp();
    logic [7:0] h[$];
    logic [7:0] c;
    bit rd, send;
    int first, n;
    exp.delete();
    rd = !instr_i[5];
    send = header_ok_i && (rd || instr_i[3]);
    if (!send) return;
    first = -1;
    for (int k = 0; k < int'(path_len_i); k++)
      if (first < 0 && path_i[8*k +: 8] != 0) first = k;
    if (first >= 0)
      for (int k = first; k < int'(path_len_i); k++) exp.push_back(int'(path_i[8*k +: 8]));
    n = (rd && status_i == 0) ? int'(data_len_i) : 0;
    h = '{src_la_i, 8'h01, instr_i & 8'hBF, status_i, dst_la_i, tid_i[15:8], tid_i[7:0]};
    if (rd) begin
      h.push_back(8'h00);
      h.push_back(8'(n >> 16)); h.push_back(8'(n >> 8)); h.push_back(8'(n));
    end
    c = 0;
    foreach (h[i]) begin c = crc_upd(c, h[i]); exp.push_back(int'(h[i])); end
    exp.push_back(int'(c));
    if (rd) begin
      c = 0;
      for (int i = 0; i < n; i++) begin
        c = crc_upd(c, mem_byte(i));
        exp.push_back(int'(mem_byte(i)));
      end
      exp.push_back(int'(c));
    end
    exp.push_back(9'h100);
  endfunction

  task automatic run_case(string tag, bit rr, int exp_fetch, bit restart);
    int t;
    got.delete();
    fetched = 0;
    src_idx = 0;
    dat_i = mem_byte(0);
    rdy_rand = rr;
    build_exp();
    @(posedge clk); #1 start_i = 1;
    @(posedge clk); #1 start_i = 0;
    if (restart) begin
      repeat (3) @(posedge clk);
      #1 start_i = 1; tid_i = 16'hFFFF;
      @(posedge clk); #1 start_i = 0;
    end
    @(negedge clk);
    if (exp.size() == 0) check(!busy_o, {tag, " busy after silent start"}, busy_o, 0);
    t = 0;
    while (busy_o && t < 5000) begin @(negedge clk); t++; end
    repeat (8) @(negedge clk);
    check(got.size() == exp.size(), {tag, " beat count"}, got.size(), exp.size());
    for (int i = 0; i < got.size() && i < exp.size(); i++)
      check(got[i] == exp[i], $sformatf("%s beat %0d", tag, i), got[i], exp[i]);
    if (exp_fetch >= 0) check(fetched == exp_fetch, {tag, " fetch count"}, fetched, exp_fetch);
    rdy_rand = 0;
  endtask

  task automatic set_path(int len, int b0, int b1, int b2, int b3, int b4);
    path_i = '0;
    path_i[7:0] = 8'(b0); path_i[15:8] = 8'(b1); path_i[23:16] = 8'(b2);
    path_i[31:24] = 8'(b3); path_i[39:32] = 8'(b4);
    path_len_i = IDX_W'(len);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!busy_o && !tx_valid_o && !dat_ready_o, "R12 reset state",
          {busy_o, tx_valid_o, dat_ready_o}, 0);
  endtask

  task automatic t_write_ack();
    set_path(5, 0, 0, 5, 0, 9);
    src_la_i = 8'h21; dst_la_i = 8'hFE; instr_i = 8'h6D; tid_i = 16'h1234; status_i = 0;
    run_case("R1 R4 R5 R7 R8 R12 write ack", 0, 0, 0);
  endtask

  task automatic t_write_bp();
    set_path(0, 0, 0, 0, 0, 0);
    src_la_i = 8'h80; dst_la_i = 8'h33; instr_i = 8'h68; tid_i = 16'hBEEF; status_i = 8'h0A;
    run_case("R1 R11 write backpressure", 1, 0, 0);
  endtask

  task automatic t_write_noack();
    set_path(2, 3, 4, 0, 0, 0);
    instr_i = 8'h64; tid_i = 16'h0001;
    run_case("R2 write no ack", 0, 0, 0);
  endtask

  task automatic t_bad_header();
    header_ok_i = 0;
    instr_i = 8'h4E; data_len_i = 4; status_i = 0;
    run_case("R3 bad header read", 0, 0, 0);
    instr_i = 8'h6C;
    run_case("R3 bad header write", 0, 0, 0);
    header_ok_i = 1;
  endtask

  task automatic t_read_ok();
    set_path(3, 0, 0, 0, 0, 0);
    src_la_i = 8'h45; dst_la_i = 8'h99; instr_i = 8'h4E; tid_i = 16'hA55A;
    status_i = 0; data_len_i = 24'd5;
    run_case("R6 R9 R7 read data", 1, 5, 0);
    data_len_i = 24'd300;
    set_path(4, 0, 7, 0, 2, 0);
    run_case("R6 R9 R11 long read", 1, 300, 0);
  endtask

  task automatic t_read_err();
    set_path(1, 6, 0, 0, 0, 0);
    instr_i = 8'h4C; tid_i = 16'h0F0F; status_i = 8'h03; data_len_i = 24'd5;
    run_case("R10 read error status", 0, 0, 0);
    status_i = 0; data_len_i = 0;
    run_case("R10 read zero length", 1, 0, 0);
  endtask

  task automatic t_busy_start();
    set_path(2, 1, 2, 0, 0, 0);
    instr_i = 8'h6D; tid_i = 16'h4242; status_i = 0;
    run_case("R13 start while busy", 1, 0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_write_ack();
    t_write_bp();
    t_write_noack();
    t_bad_header();
    t_read_ok();
    t_read_err();
    t_busy_start();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule